// File: doc/BRIEF.md
# Calendar Real-Time Clock Core

This block keeps wall-clock time and a calendar inside a chip. A 32.768 kHz tick enable arrives as a single-cycle pulse on the system clock. An internal divider turns it into one time/date advance per second. The seconds, minutes, hours, weekday, day of month, month and year are each held as one byte. The values are kept in packed BCD or in plain binary. The hours byte follows a 12-hour or a 24-hour convention.

Software reaches the clock through a plain byte-wide register port. Offsets 00h–09h hold the time bytes and the three alarm bytes. Offsets 0Ah–0Dh hold the control and status registers. Shortly before each once-a-second rollover the block raises an update-in-progress flag. While that flag is up, reads of the time bytes return FFh. Three event sources can raise one level interrupt: an alarm match, a programmable periodic rate and the end of an update.

Top module: `rtc_core`

## Requirements
- R1: Exactly one time/date advance occurs per TICKS_PER_SEC asserted tick cycles, and only while control A bits [6:4] equal 3'b010 and control B bit 7 (SET) is 0. Tick cycles with the tick input low do not count toward the second.
- R2: Byte layout is 00h seconds, 02h minutes, 04h hours, 06h weekday (1–7), 07h day of month, 08h month (1–12) and 09h year (00–99). Control B bit 2 selects binary (1) or BCD (0). Each advance increments the seconds and carries through every field, with weekday wrapping 7→1 and year wrapping 99→00.
- R3: The day of month rolls over at 31, 30 or 28 days according to the month. February has 29 days when the year is a multiple of 4.
- R4: With control B bit 1 = 0 (12-hour mode), hours bit 7 is the PM flag and the hour runs 12, 1 … 11. 11 AM advances to 12 PM, 11 PM advances to 12 AM plus a new day, and 12 AM advances to 1 AM.
- R5: Control A bit 7 reads 1 during the last UIP_LEAD ticks of each second while counting is active. In that window, reads of offsets 00h–09h return FFh.
- R6: A host write to a time byte in the same cycle as an advance stores the host value. The other fields still take their advanced values.
- R7: After each advance, the new seconds, minutes and hours are compared with the alarm bytes at 01h, 03h and 05h. An alarm byte with bits [7:6] = 2'b11 matches any value. A full match sets control C bit 5.
- R8: Control A bits [3:0] = r with r ≥ 3 sets control C bit 6 once every 2^(r-1) counted ticks. With r < 3 no periodic event occurs.
- R9: Control C bit 4 is set by each advance. Control C bit 7 (and the irq output) is the OR of each flag ANDed with its enable: bit 6 with B[6], bit 5 with B[5], bit 4 with B[4]. Reading control C returns the flags and clears them.
- R10: While SET is 1, no advance occurs, control A bit 7 stays 0 and the update-ended flag is cleared.
- R11: After reset, control A reads 00h, control B reads 02h, control C reads 00h, time bytes read 00h except weekday, day and month = 01h, and irq is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle 32.768 kHz time-base enable |
| hostAddr | input | 4 | Register offset 00h–0Dh |
| hostWrEn | input | 1 | Write strobe |
| hostWrData | input | 8 | Write data |
| hostRdEn | input | 1 | Read strobe; data appears in the next cycle |
| hostRdData | output | 8 | Registered read data |
| irq | output | 1 | Level interrupt, equal to control C bit 7 |

## Verification
A host write and the once-a-second advance can fall on the same clock edge. The bench makes this happen by restarting the divider at a known edge, counting edges and issuing a seconds write exactly on the edge where the advance happens. The result passes if the seconds byte holds the written value while the minutes still show the carry. The same edge counting places reads inside and outside the update-in-progress window, and it places a control C read next to the edges that set the flags.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic update;    // advance time on this edge
    logic periodic;  // periodic event on this edge
    logic uip;       // update-in-progress window
  } rtcStrobe_t;

  typedef struct packed {
    logic       setMode;
    logic       pie;
    logic       aie;
    logic       uie;
    logic       binMode;
    logic       hr24;
    logic [2:0] divSel;
    logic [3:0] rate;
  } rtcCfg_t;

  localparam int NUM_TIME_BYTES = 10;
  localparam logic [3:0] OFF_CTRL_A = 4'd10;
  localparam logic [3:0] OFF_CTRL_B = 4'd11;
  localparam logic [3:0] OFF_CTRL_C = 4'd12;
  localparam logic [3:0] OFF_CTRL_D = 4'd13;

  function automatic logic [7:0] bcd2bin(input logic [7:0] b);
    return ({4'd0, b[7:4]} * 8'd10) + {4'd0, b[3:0]};
  endfunction

  function automatic logic [7:0] bin2bcd(input logic [7:0] v);
    logic [7:0] tens;
    logic [7:0] ones;
    tens = v / 8'd10;
    ones = v - (tens * 8'd10);
    return {tens[3:0], ones[3:0]};
  endfunction

  function automatic logic [7:0] monthDays(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'd4, 8'd6, 8'd9, 8'd11: return 8'd30;
      8'd2:                    return (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
      default:                 return 8'd31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_LEAD      = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  rtcCfg_t    cfg,
  input  logic       alarmMatch,
  input  logic       hostRdC,
  output rtcStrobe_t strobe,
  output logic [3:0] flags,
  output logic       irq
);
  localparam int DW = $clog2(TICKS_PER_SEC);
  localparam logic [DW-1:0] LAST     = DW'(TICKS_PER_SEC - 1);
  localparam logic [DW-1:0] UIP_FROM = DW'(TICKS_PER_SEC - UIP_LEAD);
  localparam logic [2:0]    DIV_RUN  = 3'b010;

  logic [DW-1:0] divCnt;
  logic [14:0]   perCnt;
  logic [14:0]   rateMask;
  logic [15:0]   rateBit;
  logic          running;
  logic          pf, af, uf, irqf;

  assign running = (cfg.divSel == DIV_RUN);

  always_ff @(posedge clk) begin
    if (!rstN || !running) begin
      divCnt <= '0;
      perCnt <= '0;
    end else if (tick) begin
      divCnt <= (divCnt == LAST) ? '0 : divCnt + 1'b1;
      perCnt <= perCnt + 15'd1;
    end
  end

  always_comb begin
    rateBit  = 16'd1 << (cfg.rate - 4'd1);
    rateMask = rateBit[14:0] - 15'd1;
  end

  assign strobe.uip      = running && !cfg.setMode && (divCnt >= UIP_FROM);
  assign strobe.update   = running && !cfg.setMode && tick && (divCnt == LAST);
  assign strobe.periodic = running && tick && (cfg.rate >= 4'd3) &&
                           (((perCnt + 15'd1) & rateMask) == 15'd0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pf <= 1'b0;
      af <= 1'b0;
      uf <= 1'b0;
    end else begin
      pf <= (pf && !hostRdC) || strobe.periodic;
      af <= (af && !hostRdC) || (strobe.update && alarmMatch);
      uf <= cfg.setMode ? 1'b0 : ((uf && !hostRdC) || strobe.update);
    end
  end

  assign irqf  = (pf && cfg.pie) || (af && cfg.aie) || (uf && cfg.uie);
  assign flags = {irqf, pf, af, uf};
  assign irq   = irqf;

  AST_UIP_LEADS_UPDATE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.update |-> $past(strobe.uip)); // R5
  AST_SET_CLEARS_UF: assert property (@(posedge clk) disable iff (!rstN)
    cfg.setMode |=> !flags[0]); // R10
  AST_READ_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (hostRdC && !strobe.periodic && !strobe.update) |=> (flags[2:0] == 3'b000)); // R9
  AST_PERIODIC_SPACED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.periodic |=> !strobe.periodic); // R8

endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] hostAddr,
  input  logic       hostWrEn,
  input  logic [7:0] hostWrData,
  input  logic       hostRdEn,
  input  rtcStrobe_t strobe,
  input  logic [3:0] flags,
  output rtcCfg_t    cfg,
  output logic       alarmMatch,
  output logic [7:0] hostRdData
);
  logic [7:0] timeReg  [NUM_TIME_BYTES];
  logic [7:0] nextTime [NUM_TIME_BYTES];
  logic [6:0] ctrlA;
  logic [7:0] ctrlB;

  assign cfg = '{setMode: ctrlB[7], pie: ctrlB[6], aie: ctrlB[5], uie: ctrlB[4],
                 binMode: ctrlB[2], hr24: ctrlB[1], divSel: ctrlA[6:4], rate: ctrlA[3:0]};

  function automatic logic [7:0] toBin(input logic [7:0] x, input logic isBin);
    return isBin ? x : bcd2bin(x);
  endfunction

  function automatic logic [7:0] fromBin(input logic [7:0] x, input logic isBin);
    return isBin ? x : bin2bcd(x);
  endfunction

  function automatic logic alarmHit(input logic [7:0] val, input logic [7:0] alm);
    return (alm[7:6] == 2'b11) || (alm == val);
  endfunction

  logic [7:0] sec, mins, h12, h24, dow, dom, mon, yr, dim;
  logic [7:0] secN, minN, hrN, dowN, domN, monN, yrN, hrMod, h12N, hrByte, h12Enc;
  logic       cMin, cHr, cDay, cMon, cYr, pmN;

  always_comb begin
    sec  = toBin(timeReg[0], cfg.binMode);
    mins = toBin(timeReg[2], cfg.binMode);
    h12  = toBin({1'b0, timeReg[4][6:0]}, cfg.binMode);
    dow  = toBin(timeReg[6], cfg.binMode);
    dom  = toBin(timeReg[7], cfg.binMode);
    mon  = toBin(timeReg[8], cfg.binMode);
    yr   = toBin(timeReg[9], cfg.binMode);
    if (cfg.hr24)          h24 = toBin(timeReg[4], cfg.binMode);
    else if (h12 == 8'd12) h24 = timeReg[4][7] ? 8'd12 : 8'd0;
    else                   h24 = timeReg[4][7] ? h12 + 8'd12 : h12;
    dim = monthDays(mon, yr);

    cMin = (sec == 8'd59);
    secN = cMin ? 8'd0 : sec + 8'd1;
    cHr  = cMin && (mins == 8'd59);
    minN = cMin ? ((mins == 8'd59) ? 8'd0 : mins + 8'd1) : mins;
    cDay = cHr && (h24 == 8'd23);
    hrN  = cHr ? ((h24 == 8'd23) ? 8'd0 : h24 + 8'd1) : h24;
    dowN = cDay ? ((dow >= 8'd7) ? 8'd1 : dow + 8'd1) : dow;
    cMon = cDay && (dom >= dim);
    domN = cDay ? ((dom >= dim) ? 8'd1 : dom + 8'd1) : dom;
    cYr  = cMon && (mon >= 8'd12);
    monN = cMon ? ((mon >= 8'd12) ? 8'd1 : mon + 8'd1) : mon;
    yrN  = cYr ? ((yr >= 8'd99) ? 8'd0 : yr + 8'd1) : yr;

    pmN    = (hrN >= 8'd12);
    hrMod  = pmN ? hrN - 8'd12 : hrN;
    h12N   = (hrMod == 8'd0) ? 8'd12 : hrMod;
    h12Enc = fromBin(h12N, cfg.binMode);
    hrByte = cfg.hr24 ? fromBin(hrN, cfg.binMode) : {pmN, h12Enc[6:0]};

    nextTime[0] = fromBin(secN, cfg.binMode);
    nextTime[1] = timeReg[1];
    nextTime[2] = fromBin(minN, cfg.binMode);
    nextTime[3] = timeReg[3];
    nextTime[4] = hrByte;
    nextTime[5] = timeReg[5];
    nextTime[6] = fromBin(dowN, cfg.binMode);
    nextTime[7] = fromBin(domN, cfg.binMode);
    nextTime[8] = fromBin(monN, cfg.binMode);
    nextTime[9] = fromBin(yrN, cfg.binMode);

    alarmMatch = alarmHit(nextTime[0], timeReg[1]) &&
                 alarmHit(nextTime[2], timeReg[3]) &&
                 alarmHit(nextTime[4], timeReg[5]);
  end

  for (genvar i = 0; i < NUM_TIME_BYTES; i++) begin : g_timeByte
    localparam logic [7:0] RST_VAL = (i >= 6 && i <= 8) ? 8'h01 : 8'h00;
    always_ff @(posedge clk) begin
      if (!rstN)                                        timeReg[i] <= RST_VAL;
      else if (hostWrEn && (hostAddr == 4'(i)))         timeReg[i] <= hostWrData;
      else if (strobe.update)                           timeReg[i] <= nextTime[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlA      <= 7'h00;
      ctrlB      <= 8'h02;
      hostRdData <= 8'h00;
    end else begin
      if (hostWrEn && hostAddr == OFF_CTRL_A) ctrlA <= hostWrData[6:0];
      if (hostWrEn && hostAddr == OFF_CTRL_B) ctrlB <= hostWrData;
      if (hostRdEn) begin
        if (hostAddr < 4'(NUM_TIME_BYTES)) hostRdData <= strobe.uip ? 8'hFF : timeReg[hostAddr];
        else if (hostAddr == OFF_CTRL_A)   hostRdData <= {strobe.uip, ctrlA};
        else if (hostAddr == OFF_CTRL_B)   hostRdData <= ctrlB;
        else if (hostAddr == OFF_CTRL_C)   hostRdData <= {flags, 4'h0};
        else if (hostAddr == OFF_CTRL_D)   hostRdData <= 8'h80;
        else                               hostRdData <= 8'h00;
      end
    end
  end

  AST_HOST_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hostAddr == 4'd0 && strobe.update) |=> (timeReg[0] == $past(hostWrData))); // R6

endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_LEAD      = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic [3:0] hostAddr,
  input  logic       hostWrEn,
  input  logic [7:0] hostWrData,
  input  logic       hostRdEn,
  output logic [7:0] hostRdData,
  output logic       irq
);
  rtcStrobe_t strobe;
  rtcCfg_t    cfg;
  logic [3:0] flags;
  logic       alarmMatch;
  logic       hostRdC;

  assign hostRdC = hostRdEn && (hostAddr == OFF_CTRL_C);

  rtc_ctrl #(.TICKS_PER_SEC(TICKS_PER_SEC), .UIP_LEAD(UIP_LEAD)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .cfg(cfg), .alarmMatch(alarmMatch),
    .hostRdC(hostRdC), .strobe(strobe), .flags(flags), .irq(irq)
  );

  rtc_datapath u_datapath (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostWrData(hostWrData), .hostRdEn(hostRdEn), .strobe(strobe), .flags(flags),
    .cfg(cfg), .alarmMatch(alarmMatch), .hostRdData(hostRdData)
  );

endmodule

// File: tb/rtc_core_bench.sv
module rtc_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TPS        = 64;
  localparam int LEAD       = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b1;
  logic [3:0] hostAddr = '0;
  logic       hostWrEn = 1'b0;
  logic [7:0] hostWrData = '0;
  logic       hostRdEn = 1'b0;
  logic [7:0] hostRdData;
  logic       irq;
  int         errors = 0;
  int         checks = 0;
  logic [7:0] rd;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rtc_core #(.TICKS_PER_SEC(TPS), .UIP_LEAD(LEAD)) u_rtc_core (
    .clk(clk), .rstN(rstN), .tick(tick), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostWrData(hostWrData), .hostRdEn(hostRdEn), .hostRdData(hostRdData), .irq(irq)
  );

  // {mode, sec, min, hr, dow, dom, mon, yr, then expected sec..yr}
  localparam logic [119:0] VEC [9] = '{
    120'h02_59_59_23_07_31_12_99_00_00_00_01_01_01_00,  // R2 full carry
    120'h02_59_59_23_03_28_02_24_00_00_00_04_29_02_24,  // R3 leap Feb
    120'h02_59_59_23_03_28_02_23_00_00_00_04_01_03_23,  // R3 plain Feb
    120'h06_3B_3B_17_02_1E_04_05_00_00_00_03_01_05_05,  // R2 binary, 30-day month
    120'h00_59_59_11_01_15_06_30_00_00_92_01_15_06_30,  // R4 11AM->12PM
    120'h00_59_59_91_01_15_06_30_00_00_12_02_16_06_30,  // R4 11PM->12AM
    120'h00_59_59_12_05_10_03_40_00_00_01_05_10_03_40,  // R4 12AM->1AM
    120'h02_09_59_10_03_10_03_40_10_59_10_03_10_03_40,  // R2 BCD digit carry
    120'h06_09_3B_0A_03_0A_03_28_0A_3B_0A_03_0A_03_28   // R2 binary no carry
  };
  localparam logic [3:0] TIME_OFF [7] = '{4'd0, 4'd2, 4'd4, 4'd6, 4'd7, 4'd8, 4'd9};

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    hostAddr = a; hostWrData = d; hostWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [3:0] a, output logic [7:0] d);
    hostAddr = a; hostRdEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    hostRdEn = 1'b0;
    d = hostRdData;
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // divider restarts at the edge of the second write; returns at the negedge after it
  task automatic startDiv(input logic [7:0] aVal);
    wrReg(4'd10, 8'h00);
    hostAddr = 4'd10; hostWrData = aVal; hostWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R11 reset state
    check("R11 irq", {7'd0, irq}, 8'h00);
    rdReg(4'd10, rd); check("R11 ctrlA", rd, 8'h00);
    rdReg(4'd11, rd); check("R11 ctrlB", rd, 8'h02);
    rdReg(4'd12, rd); check("R11 ctrlC", rd, 8'h00);
    rdReg(4'd0,  rd); check("R11 sec", rd, 8'h00);
    rdReg(4'd7,  rd); check("R11 dom", rd, 8'h01);

    // Vector walk: R2 R3 R4
    for (int v = 0; v < 9; v++) begin
      wrReg(4'd10, 8'h00);
      wrReg(4'd11, 8'h80 | VEC[v][119 -: 8]);
      for (int k = 0; k < 7; k++) wrReg(TIME_OFF[k], VEC[v][111 - 8*k -: 8]);
      wrReg(4'd1, 8'h7E); wrReg(4'd3, 8'h7E); wrReg(4'd5, 8'h7E);
      wrReg(4'd11, VEC[v][119 -: 8]);
      startDiv(8'h20);
      waitEdges(70);
      for (int k = 0; k < 7; k++) begin
        rdReg(TIME_OFF[k], rd);
        check($sformatf("R2/R3/R4 vector %0d byte %0d", v, k), rd, VEC[v][55 - 8*k -: 8]);
      end
    end

    // R1: invalid divider select and idle tick
    wrReg(4'd10, 8'h00); wrReg(4'd11, 8'h82); wrReg(4'd0, 8'h10); wrReg(4'd11, 8'h02);
    waitEdges(100);
    rdReg(4'd0, rd); check("R1 no advance when divider select invalid", rd, 8'h10);
    tick = 1'b0;
    startDiv(8'h20);
    waitEdges(100);
    rdReg(4'd0, rd); check("R1 no advance without tick", rd, 8'h10);
    tick = 1'b1;
    waitEdges(66);
    rdReg(4'd0, rd); check("R1 one advance after a second of ticks", rd, 8'h11);
    waitEdges(20);
    rdReg(4'd0, rd); check("R1 single advance per second", rd, 8'h11);

    // R5: update-in-progress window
    wrReg(4'd10, 8'h00); wrReg(4'd11, 8'h82); wrReg(4'd0, 8'h20); wrReg(4'd11, 8'h02);
    startDiv(8'h20);
    waitEdges(40);
    rdReg(4'd10, rd); check("R5 flag low early in second", rd, 8'h20);
    waitEdges(9);
    rdReg(4'd10, rd); check("R5 flag high in window", rd, 8'hA0);
    rdReg(4'd0, rd);  check("R5 time read blocked in window", rd, 8'hFF);
    waitEdges(14);
    rdReg(4'd0, rd);  check("R5 time readable after advance", rd, 8'h21);
    rdReg(4'd10, rd); check("R5 flag low after advance", rd, 8'h20);

    // R10: SET halts time, keeps flag low, clears update-ended flag
    wrReg(4'd10, 8'h00); wrReg(4'd11, 8'h92); wrReg(4'd0, 8'h30);
    startDiv(8'h20);
    waitEdges(55);
    rdReg(4'd10, rd); check("R10 no in-progress flag under SET", rd, 8'h20);
    waitEdges(45);
    rdReg(4'd0, rd);  check("R10 no advance under SET", rd, 8'h30);
    rdReg(4'd12, rd); check("R10 no update flag under SET", rd, 8'h00);
    wrReg(4'd10, 8'h00); wrReg(4'd11, 8'h12);
    startDiv(8'h20);
    waitEdges(66);
    check("R9 update-ended raises irq", {7'd0, irq}, 8'h01);
    wrReg(4'd11, 8'h92);
    waitEdges(1);
    check("R10 SET drops irq", {7'd0, irq}, 8'h00);
    rdReg(4'd12, rd); check("R10 SET cleared update flag", rd, 8'h00);

    // R6: host write on the advance edge
    wrReg(4'd10, 8'h00); wrReg(4'd11, 8'h82); wrReg(4'd0, 8'h59); wrReg(4'd2, 8'h00);
    wrReg(4'd11, 8'h02);
    startDiv(8'h20);
    waitEdges(62);
    wrReg(4'd0, 8'h30);  // write edge is the 64th edge after the restart
    waitEdges(2);
    rdReg(4'd0, rd); check("R6 host value kept on collision", rd, 8'h30);
    rdReg(4'd2, rd); check("R6 minutes still carried", rd, 8'h01);

    // R7 R9: alarm with wildcards
    wrReg(4'd10, 8'h00); wrReg(4'd11, 8'h82);
    wrReg(4'd0, 8'h04); wrReg(4'd1, 8'h05); wrReg(4'd2, 8'h10); wrReg(4'd3, 8'hC0);
    wrReg(4'd4, 8'h08); wrReg(4'd5, 8'hFF);
    wrReg(4'd11, 8'h22);
    startDiv(8'h20);
    waitEdges(66);
    check("R7 alarm raises irq", {7'd0, irq}, 8'h01);
    rdReg(4'd12, rd); check("R9 flags on alarm", rd, 8'hB0);
    check("R9 read clears irq", {7'd0, irq}, 8'h00);
    rdReg(4'd12, rd); check("R9 second read empty", rd, 8'h00);
    waitEdges(62);
    check("R7 no irq without match", {7'd0, irq}, 8'h00);
    rdReg(4'd12, rd); check("R7 only update flag without match", rd, 8'h10);

    // R8: periodic rate
    wrReg(4'd10, 8'h00); wrReg(4'd11, 8'h42);
    startDiv(8'h23);
    check("R8 no periodic at start", {7'd0, irq}, 8'h00);
    waitEdges(2);
    check("R8 no periodic before 4 ticks", {7'd0, irq}, 8'h00);
    waitEdges(2);
    check("R8 periodic after 4 ticks", {7'd0, irq}, 8'h01);
    rdReg(4'd12, rd); check("R8 periodic flags", rd, 8'hC0);
    startDiv(8'h20);
    rdReg(4'd12, rd);
    waitEdges(30);
    check("R8 rate 0 gives no periodic", {7'd0, irq}, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule